// File: doc/BRIEF.md
# Single-Precision Minimum/Maximum Unit

This block returns the smaller or the larger of two single-precision floating-point operands. A select input chooses between the two operations. The block also raises a one-bit invalid-operation flag, which the caller must fold into its own accrued exception state. The block has one cycle of latency: the operands and the select are sampled on a rising clock edge, and the result and the flag appear on registered outputs after that edge.

Each operand is sorted into one of four classes: ordinary number (which includes infinities and subnormals), zero, quiet NaN or signaling NaN. Ordinary numbers and zeros are placed in a total order in which negative zero sits below positive zero. A NaN of either kind that is paired with a non-NaN operand is passed over, and the non-NaN operand is returned. A signaling NaN still raises the invalid flag in that case, even though the result is not a NaN. When both operands are NaN, the result is the canonical quiet NaN.

Top module: `fp_minmax_unit`

## Requirements
- R1: While `rst_n` is low, `result` is 0x00000000 and `invalid` is 0.
- R2: `result` and `invalid` change only on a rising clock edge. After an edge they show the outcome for the operands and select sampled at that edge, and they hold that outcome until the next edge.
- R3: For two non-NaN operands, `sel_max`=0 returns the operand with the lower numeric value and `sel_max`=1 returns the higher one. Infinities and subnormals are included. If both operands carry the same encoding, that encoding is returned.
- R4: Negative zero (0x80000000) orders below positive zero (0x00000000). The minimum of the two zeros is 0x80000000 and the maximum is 0x00000000, whichever operand holds which zero.
- R5: A signaling NaN paired with a non-NaN operand yields the non-NaN operand bit for bit, with `invalid`=1, for both minimum and maximum. A signaling NaN has exponent bits [30:23] all ones, bit 22 clear and bits [21:0] nonzero.
- R6: A quiet NaN paired with a non-NaN operand yields the non-NaN operand bit for bit, with `invalid`=0, for both minimum and maximum. A quiet NaN has exponent bits [30:23] all ones and bit 22 set.
- R7: When both operands are NaNs of any kind, `result` is 0x7FC00000 for both minimum and maximum.
- R8: `invalid` is 1 exactly when at least one sampled operand is a signaling NaN. Any NaN that appears on `result` is 0x7FC00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_a | input | 32 | First operand, single-precision encoding |
| in_b | input | 32 | Second operand, single-precision encoding |
| sel_max | input | 1 | 0 selects minimum, 1 selects maximum |
| result | output | 32 | Registered minimum or maximum |
| invalid | output | 1 | Registered invalid-operation flag |

## Verification
The unit holds no state beyond its output registers, so a wrong classification or a wrong ordering decision shows on the ports in the cycle after the offending operands are sampled. A misclassified signaling NaN shows up in one of two ways: `invalid` drops, or a non-canonical NaN leaks out. A faulty sign-magnitude order shows as the wrong operand on a pair of mixed signs or a pair of signed zeros. The directed scenarios pair every operand class with every other class, under both selects and in both operand positions. A randomized sweep then compares against an independent ordering model written in the bench.

// File: rtl/fpmm_pkg.sv
// Package: shared operand classes for the minimum/maximum unit.
// Assumes a binary interchange encoding of the form {sign, exponent, mantissa}.
package fpmm_pkg;

    // Operand class. Ordinary numbers include infinities and subnormals.
    typedef enum logic [1:0] {
        CLS_NUM  = 2'd0,
        CLS_ZERO = 2'd1,
        CLS_QNAN = 2'd2,
        CLS_SNAN = 2'd3
    } fpmm_cls_e;

    // True for either NaN class.
    function automatic logic cls_is_nan(input fpmm_cls_e c);
        return (c == CLS_QNAN) || (c == CLS_SNAN);
    endfunction

endpackage

// File: rtl/fpmm_classify.sv
// Module: fpmm_classify
// Sorts one operand into number, zero, quiet NaN or signaling NaN.
// Assumes the mantissa MSB is the quiet bit and that MAN_W >= 2.
module fpmm_classify
    import fpmm_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] value,
    output fpmm_cls_e            cls
);
    localparam int W = 1 + EXP_W + MAN_W;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    assign exp_f = value[W-2 -: EXP_W];
    assign man_f = value[MAN_W-1:0];

    // Purpose: decode the exponent and mantissa fields into a class.
    always_comb begin
        if (&exp_f && (man_f != '0)) begin
            cls = man_f[MAN_W-1] ? CLS_QNAN : CLS_SNAN;
        end else if ((exp_f == '0) && (man_f == '0)) begin
            cls = CLS_ZERO;
        end else begin
            cls = CLS_NUM;
        end
    end
endmodule

// File: rtl/fpmm_order.sv
// Module: fpmm_order
// Decides whether operand a orders strictly below operand b.
// Assumes neither operand is a NaN; the NaN cases are resolved downstream.
// Negative zero orders below positive zero.
module fpmm_order #(
    parameter int W = 32
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         a_below_b
);
    logic [W-1:0] key_a;
    logic [W-1:0] key_b;

    // Purpose: map sign-magnitude encodings onto keys that compare as unsigned.
    always_comb begin
        key_a = op_a[W-1] ? ~op_a : {1'b1, op_a[W-2:0]};
        key_b = op_b[W-1] ? ~op_b : {1'b1, op_b[W-2:0]};
    end

    // Purpose: one unsigned comparison settles the order.
    assign a_below_b = key_a < key_b;
endmodule

// File: rtl/fpmm_pick.sv
// Module: fpmm_pick
// Applies the NaN rules and the min/max choice, and derives the invalid flag.
// Assumes the classes and the order bit come from fpmm_classify and fpmm_order.
module fpmm_pick
    import fpmm_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] op_a,
    input  logic [EXP_W+MAN_W:0] op_b,
    input  fpmm_cls_e            cls_a,
    input  fpmm_cls_e            cls_b,
    input  logic                 a_below_b,
    input  logic                 want_max,
    output logic [EXP_W+MAN_W:0] pick,
    output logic                 raise_nv
);
    localparam int W = 1 + EXP_W + MAN_W;
    localparam logic [W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic nan_a;
    logic nan_b;

    assign nan_a = cls_is_nan(cls_a);
    assign nan_b = cls_is_nan(cls_b);

    // Purpose: choose the canonical NaN, the non-NaN operand, or the ordered winner.
    always_comb begin
        if (nan_a && nan_b) begin
            pick = CANON_NAN;
        end else if (nan_a) begin
            pick = op_b;
        end else if (nan_b) begin
            pick = op_a;
        end else if (want_max) begin
            pick = a_below_b ? op_b : op_a;
        end else begin
            pick = a_below_b ? op_a : op_b;
        end
    end

    // Purpose: signaling NaNs raise invalid whatever the result is.
    assign raise_nv = (cls_a == CLS_SNAN) || (cls_b == CLS_SNAN);
endmodule

// File: rtl/fp_minmax_unit.sv
// Module: fp_minmax_unit
// Top of the single-precision minimum/maximum unit. It classifies both
// operands, orders them, applies the NaN rules and registers the result
// and the invalid flag. Latency is one cycle. Reset is synchronous and
// active low.
module fp_minmax_unit
    import fpmm_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [EXP_W+MAN_W:0] in_a,
    input  logic [EXP_W+MAN_W:0] in_b,
    input  logic                 sel_max,
    output logic [EXP_W+MAN_W:0] result,
    output logic                 invalid
);
    localparam int W     = 1 + EXP_W + MAN_W;
    localparam int N_OPS = 2;

    logic [W-1:0] ops [N_OPS];
    fpmm_cls_e    cls [N_OPS];
    logic         a_below_b;
    logic [W-1:0] pick;
    logic         raise_nv;

    assign ops[0] = in_a;
    assign ops[1] = in_b;

    // One classifier per operand.
    for (genvar i = 0; i < N_OPS; i++) begin : g_cls
        fpmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .value (ops[i]),
            .cls   (cls[i])
        );
    end

    fpmm_order #(.W(W)) u_order (
        .op_a      (in_a),
        .op_b      (in_b),
        .a_below_b (a_below_b)
    );

    fpmm_pick #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_pick (
        .op_a      (in_a),
        .op_b      (in_b),
        .cls_a     (cls[0]),
        .cls_b     (cls[1]),
        .a_below_b (a_below_b),
        .want_max  (sel_max),
        .pick      (pick),
        .raise_nv  (raise_nv)
    );

    // Purpose: output registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result  <= '0;
            invalid <= 1'b0;
        end else begin
            result  <= pick;
            invalid <= raise_nv;
        end
    end
endmodule

// File: rtl/fpmm_checker.sv
// Module: fpmm_checker
// Port-level properties of fp_minmax_unit, attached by bind.
// Assumes one cycle of latency and a synchronous active-low reset.
module fpmm_checker #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [EXP_W+MAN_W:0] in_a,
    input logic [EXP_W+MAN_W:0] in_b,
    input logic                 sel_max,
    input logic [EXP_W+MAN_W:0] result,
    input logic                 invalid
);
    localparam int W = 1 + EXP_W + MAN_W;
    localparam logic [W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic a_nan, b_nan, a_snan, b_snan, a_zero, b_zero, r_nan;

    // Purpose: classify the operands and the result independently of the design.
    always_comb begin
        a_nan  = &in_a[W-2 -: EXP_W] && (in_a[MAN_W-1:0] != '0);
        b_nan  = &in_b[W-2 -: EXP_W] && (in_b[MAN_W-1:0] != '0);
        a_snan = a_nan && !in_a[MAN_W-1];
        b_snan = b_nan && !in_b[MAN_W-1];
        a_zero = (in_a[W-2:0] == '0);
        b_zero = (in_b[W-2:0] == '0);
        r_nan  = &result[W-2 -: EXP_W] && (result[MAN_W-1:0] != '0);
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && !invalid));

    p_operand_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(a_nan) && !$past(b_nan)
        |-> (result == $past(in_a) || result == $past(in_b)));

    p_zero_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(a_zero && b_zero && (in_a[W-1] != in_b[W-1]))
        |-> (result[W-1] == !$past(sel_max)));

    p_snan_number_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(a_snan && !b_nan)
        |-> (result == $past(in_b) && invalid));

    p_nan_number_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(!a_nan && b_nan)
        |-> (result == $past(in_a)));

    p_both_nan_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(a_nan && b_nan) |-> (result == CANON_NAN));

    p_invalid_exact_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (invalid == $past(a_snan || b_snan)));

    p_nan_canonical_r8: assert property (@(posedge clk) disable iff (!rst_n)
        r_nan |-> (result == CANON_NAN));
endmodule

bind fp_minmax_unit fpmm_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_fpmm_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_a    (in_a),
    .in_b    (in_b),
    .sel_max (sel_max),
    .result  (result),
    .invalid (invalid)
);

// File: tb/fp_minmax_unit_bench.sv
// Bench: directed scenarios plus a random sweep against a bench-side model.
module fp_minmax_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        sel_max = 1'b0;
    logic [31:0] result;
    logic        invalid;

    int total = 0;
    int bad   = 0;

    localparam logic [31:0] CNAN = 32'h7FC00000;
    localparam logic [31:0] PZ   = 32'h00000000;
    localparam logic [31:0] NZ   = 32'h80000000;
    localparam logic [31:0] SNAN = 32'h7F800001;
    localparam logic [31:0] SNN  = 32'hFFA00000;
    localparam logic [31:0] QNAN = 32'h7FC12345;
    localparam logic [31:0] QNN  = 32'hFFC00000;
    localparam logic [31:0] ONE  = 32'h3F800000;
    localparam logic [31:0] MTWO = 32'hC0000000;
    localparam logic [31:0] PINF = 32'h7F800000;
    localparam logic [31:0] NINF = 32'hFF800000;
    localparam logic [31:0] SUBN = 32'h00000001;

    always #5 clk = ~clk;

    fp_minmax_unit u_fp_minmax_unit (
        .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b),
        .sel_max(sel_max), .result(result), .invalid(invalid)
    );

    function automatic logic is_nan(input logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction

    function automatic logic is_snan(input logic [31:0] v);
        return is_nan(v) && !v[22];
    endfunction

    // Strict numeric order on sign-magnitude values, -0 below +0.
    function automatic logic ref_lt(input logic [31:0] a, input logic [31:0] b);
        if (a == b) return 1'b0;
        if (a[31] != b[31]) return a[31];
        if (!a[31]) return a[30:0] < b[30:0];
        return a[30:0] > b[30:0];
    endfunction

    function automatic logic [31:0] ref_res(input logic [31:0] a, input logic [31:0] b,
                                            input logic mx);
        if (is_nan(a) && is_nan(b)) return CNAN;
        if (is_nan(a)) return b;
        if (is_nan(b)) return a;
        if (mx) return ref_lt(a, b) ? b : a;
        return ref_lt(a, b) ? a : b;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp,
                         input logic gi, input logic ei);
        total++;
        if (got !== exp || gi !== ei) begin
            bad++;
            $display("FAIL %s: result=%h invalid=%b expected result=%h invalid=%b",
                     tag, got, gi, exp, ei);
        end
    endtask

    // Drive one operation, let one edge pass, then compare away from the edge.
    task automatic run_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                          input logic mx);
        @(negedge clk);
        in_a = a; in_b = b; sel_max = mx;
        @(negedge clk);
        check(tag, result, ref_res(a, b, mx), invalid, is_snan(a) || is_snan(b));
    endtask

    task automatic t_reset;
        in_a = ONE; in_b = SNAN; sel_max = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset", result, 32'h0, invalid, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_numbers;
        for (int m = 0; m < 2; m++) begin
            run_op("R3 one/-two", ONE, MTWO, m[0]);
            run_op("R3 -two/one", MTWO, ONE, m[0]);
            run_op("R3 infinities", NINF, PINF, m[0]);
            run_op("R3 subnormal/one", SUBN, ONE, m[0]);
            run_op("R3 equal", ONE, ONE, m[0]);
            run_op("R3 neg pair", MTWO, 32'hBF800000, m[0]);
        end
    endtask

    task automatic t_zeros;
        run_op("R4 min +0,-0", PZ, NZ, 1'b0);
        run_op("R4 min -0,+0", NZ, PZ, 1'b0);
        run_op("R4 max +0,-0", PZ, NZ, 1'b1);
        run_op("R4 max -0,+0", NZ, PZ, 1'b1);
    endtask

    task automatic t_snan;
        for (int m = 0; m < 2; m++) begin
            run_op("R5 snan,one", SNAN, ONE, m[0]);
            run_op("R5 -two,snan", MTWO, SNN, m[0]);
            run_op("R5 snan,-0", SNN, NZ, m[0]);
            run_op("R5 +inf,snan", PINF, SNAN, m[0]);
        end
    endtask

    task automatic t_qnan;
        for (int m = 0; m < 2; m++) begin
            run_op("R6 qnan,one", QNAN, ONE, m[0]);
            run_op("R6 -inf,qnan", NINF, QNN, m[0]);
            run_op("R6 qnan,+0", QNN, PZ, m[0]);
        end
    endtask

    task automatic t_both_nan;
        for (int m = 0; m < 2; m++) begin
            run_op("R7 qnan,qnan", QNAN, QNN, m[0]);
            run_op("R7 snan,qnan", SNAN, QNAN, m[0]);
            run_op("R7 qnan,snan", QNN, SNN, m[0]);
            run_op("R7 snan,snan", SNAN, SNN, m[0]);
        end
    endtask

    // The all-ones-exponent boundaries: infinity is not a NaN, mantissa MSB decides quietness.
    task automatic t_invalid_edges;
        run_op("R8 inf vs max finite", PINF, 32'h7F7FFFFF, 1'b0);
        run_op("R8 snan all bits", 32'h7FBFFFFF, ONE, 1'b1);
        run_op("R8 qnan only msb", 32'h7FC00000, MTWO, 1'b0);
    endtask

    task automatic t_latency;
        run_op("R2 setup", ONE, MTWO, 1'b0);
        @(negedge clk);
        in_a = SNAN; in_b = PINF; sel_max = 1'b1;
        #2;
        check("R2 hold before edge", result, MTWO, invalid, 1'b0);
        @(negedge clk);
        check("R2 update after edge", result, PINF, invalid, 1'b1);
    endtask

    task automatic t_random;
        for (int k = 0; k < 400; k++) begin
            logic [31:0] a, b;
            a = $urandom();
            b = $urandom();
            if (k % 8 == 0) a[30:23] = 8'hFF;
            if (k % 11 == 0) b[30:23] = 8'hFF;
            if (k % 13 == 0) a[30:0] = '0;
            run_op("R3 random", a, b, k[0]);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_numbers();
        t_zeros();
        t_snan();
        t_qnan();
        t_both_nan();
        t_invalid_edges();
        t_latency();
        t_random();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule